// File: doc/BRIEF.md
# Unit Enable and Slow-Clock Gating Controller

This block decides, every cycle, which of six large on-chip units may run and how fast the system clock ticks. It holds a per-unit power-save register and merges three independent sources with fixed priorities. The sources are that register, the processor's idle state and a slow-down control bit. The result is one enable per unit, a clock-enable pulse that divides the system rate, and a masked copy of the bus requests raised by the units that slow-down stops.

Priority is fixed. Idle turns off all six units, but it leaves a wake-up enable for the control ADC running. Slow-down turns off the acquisition, slicer and display units and masks their bus requests. A unit whose power-save bit is clear stays off whatever else happens. When idle or slow-down ends, every unit goes back to exactly what its power-save bit says. Slow-down divides the clock by `DIV_RATIO` (4 by default) through a clock-enable pulse. A change of the slow-down bit is adopted only at the boundary of a divide period, so no short clock period is ever produced.

Top module: `pwr_gate_ctrl`

## Requirements
- R1: The power-save register resets asynchronously, including a reset in the middle of operation, to all units enabled (`PSAVE_RST` = 6'h3F). After reset the divide phase is 0 and slow-down is inactive.
- R2: A cycle with `psave_we_i` high loads `psave_wdata_i` into the register at the clock edge. Bit 0 is the video ADC, 1 acquisition, 2 slicer, 3 display, 4 control ADC and 5 DAC. With idle and slow-down both inactive, `unit_en_o[i]` equals register bit i.
- R3: While `idle_i` is high, all six bits of `unit_en_o` are 0 and `wake_en_o` is 1. While `idle_i` is low, `wake_en_o` is 0.
- R4: When idle ends, each enable returns to its power-save bit, so a unit disabled in the register stays disabled.
- R5: While slow-down is active (`slow_o` = 1), enable bits 1, 2 and 3 are 0 regardless of the register. Bits 0, 4 and 5 still follow the register and idle.
- R6: `bus_req_o` equals `bus_req_i` while slow-down is inactive and is all zero while it is active. Bit 0 is acquisition, 1 slicer and 2 display.
- R7: While slow-down is inactive, `clk_en_o` is 1 every cycle. While it is active, `clk_en_o` is 1 only in divide phase 0, so it is 1 in exactly one of every `DIV_RATIO` cycles.
- R8: The divide phase counts 0 to `DIV_RATIO`-1 continuously from reset. `slow_i` is sampled only on the edge that leaves the last phase, and `slow_o` shows the value that is in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psave_we_i | input | 1 | Power-save register write strobe |
| psave_wdata_i | input | 6 | Power-save register write data, one bit per unit |
| idle_i | input | 1 | Processor idle state |
| slow_i | input | 1 | Requested slow-down bit |
| bus_req_i | input | 3 | Bus requests from acquisition, slicer, display |
| unit_en_o | output | 6 | Per-unit run enables |
| wake_en_o | output | 1 | Control ADC wake-up logic enable |
| clk_en_o | output | 1 | System clock-enable pulse |
| slow_o | output | 1 | Slow-down in effect |
| bus_req_o | output | 3 | Bus requests after the slow-down mask |

## Verification
A corrupted power-save bit shows on its unit enable in the first cycle in which idle and slow-down are both inactive. A register that idle wrongly overwrote shows in the cycle after idle ends. A wrong divide phase or slow-down latch shows within one divide period, as a `clk_en_o` pulse out of phase or a `slow_o` change away from a boundary. The bench keeps its own model of the register, the phase and the effective slow-down bit, and it compares every output after every edge. Its random traffic switches idle and slow-down at all phases.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;
  localparam int unsigned NUM_UNITS = 6;
  localparam int unsigned NUM_REQ   = 3;

  typedef enum logic [2:0] {
    U_VADC  = 3'd0,
    U_ACQ   = 3'd1,
    U_SLICE = 3'd2,
    U_DISP  = 3'd3,
    U_CADC  = 3'd4,
    U_DAC   = 3'd5
  } unit_e;

  typedef logic [NUM_UNITS-1:0] unit_vec_t;
  typedef logic [NUM_REQ-1:0]   req_vec_t;

  // units stopped by slow-down
  localparam unit_vec_t SLOW_STOP = unit_vec_t'((1 << U_ACQ) | (1 << U_SLICE) | (1 << U_DISP));
endpackage

// File: rtl/pwr_psave_reg.sv
module pwr_psave_reg
  import pwr_gate_pkg::*;
#(
  parameter unit_vec_t RST_VAL = '1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      we_i,
  input  unit_vec_t wdata_i,
  output unit_vec_t q_o
);
  unit_vec_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= RST_VAL;
    else if (we_i) q <= wdata_i;
  end

  assign q_o = q;
endmodule

// File: rtl/pwr_slow_div.sv
module pwr_slow_div #(
  parameter int unsigned DIV_RATIO = 4,
  localparam int unsigned CW       = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1,
  localparam logic [CW-1:0] LAST   = CW'(DIV_RATIO - 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_i,
  output logic slow_o,
  output logic clk_en_o
);
  logic [CW-1:0] phase;
  logic          slow_q;
  logic          at_end;

  assign at_end = (phase == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase  <= '0;
      slow_q <= 1'b0;
    end else begin
      phase <= at_end ? '0 : phase + 1'b1;
      if (at_end) slow_q <= slow_i;  // adopt only at period boundary
    end
  end

  assign slow_o   = slow_q;
  assign clk_en_o = !slow_q || (phase == '0);
endmodule

// File: rtl/pwr_unit_gate.sv
module pwr_unit_gate
  import pwr_gate_pkg::*;
(
  input  unit_vec_t psave_i,
  input  logic      idle_i,
  input  logic      slow_i,
  input  req_vec_t  req_i,
  output unit_vec_t en_o,
  output logic      wake_en_o,
  output req_vec_t  req_o
);
  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
    if (SLOW_STOP[i]) begin : g_slowed
      assign en_o[i] = psave_i[i] & ~idle_i & ~slow_i;
    end else begin : g_plain
      assign en_o[i] = psave_i[i] & ~idle_i;
    end
  end

  for (genvar j = 0; j < NUM_REQ; j++) begin : g_req
    assign req_o[j] = req_i[j] & ~slow_i;
  end

  assign wake_en_o = idle_i;
endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl
  import pwr_gate_pkg::*;
#(
  parameter int unsigned DIV_RATIO = 4,
  parameter unit_vec_t   PSAVE_RST = '1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       psave_we_i,
  input  logic [5:0] psave_wdata_i,
  input  logic       idle_i,
  input  logic       slow_i,
  input  logic [2:0] bus_req_i,
  output logic [5:0] unit_en_o,
  output logic       wake_en_o,
  output logic       clk_en_o,
  output logic       slow_o,
  output logic [2:0] bus_req_o
);
  unit_vec_t psave_q;
  logic      slow_eff;

  pwr_psave_reg #(.RST_VAL(PSAVE_RST)) u_psave (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (psave_we_i),
    .wdata_i (psave_wdata_i),
    .q_o     (psave_q)
  );

  pwr_slow_div #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .slow_i   (slow_i),
    .slow_o   (slow_eff),
    .clk_en_o (clk_en_o)
  );

  pwr_unit_gate u_gate (
    .psave_i   (psave_q),
    .idle_i    (idle_i),
    .slow_i    (slow_eff),
    .req_i     (bus_req_i),
    .en_o      (unit_en_o),
    .wake_en_o (wake_en_o),
    .req_o     (bus_req_o)
  );

  assign slow_o = slow_eff;
endmodule

// File: rtl/pwr_gate_ctrl_chk.sv
module pwr_gate_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       psave_we_i,
  input logic [5:0] psave_wdata_i,
  input logic       idle_i,
  input logic [5:0] unit_en_o,
  input logic       wake_en_o,
  input logic       clk_en_o,
  input logic       slow_o,
  input logic [2:0] bus_req_o
);
  AST_IDLE_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> (unit_en_o == 6'b0)); // R3
  AST_IDLE_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> wake_en_o); // R3
  AST_PSAVE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psave_we_i |=> (idle_i || (unit_en_o[0] == $past(psave_wdata_i[0])
                              && unit_en_o[5:4] == $past(psave_wdata_i[5:4])))); // R2
  AST_SLOW_UNITS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_o |-> (unit_en_o[3:1] == 3'b0)); // R5
  AST_SLOW_REQ_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_o |-> (bus_req_o == 3'b0)); // R6
  AST_FAST_EVERY_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slow_o |-> clk_en_o); // R7
  AST_SLOW_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow_o && clk_en_o) |=> !clk_en_o); // R7
  AST_SLOW_CHANGE_ON_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow_o != $past(slow_o)) |-> clk_en_o); // R8
endmodule

bind pwr_gate_ctrl pwr_gate_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .psave_we_i    (psave_we_i),
  .psave_wdata_i (psave_wdata_i),
  .idle_i        (idle_i),
  .unit_en_o     (unit_en_o),
  .wake_en_o     (wake_en_o),
  .clk_en_o      (clk_en_o),
  .slow_o        (slow_o),
  .bus_req_o     (bus_req_o)
);

// File: tb/pwr_gate_ctrl_tb.sv
module pwr_gate_ctrl_tb;
  localparam int unsigned DIV = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       psave_we_i = 1'b0;
  logic [5:0] psave_wdata_i = '0;
  logic       idle_i = 1'b0;
  logic       slow_i = 1'b0;
  logic [2:0] bus_req_i = '0;
  logic [5:0] unit_en_o;
  logic       wake_en_o, clk_en_o, slow_o;
  logic [2:0] bus_req_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  logic [5:0] m_psave;
  int         m_phase;
  logic       m_slow;
  logic       prev_idle;

  always #2.5 clk = ~clk;

  pwr_gate_ctrl #(.DIV_RATIO(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .psave_we_i(psave_we_i), .psave_wdata_i(psave_wdata_i),
    .idle_i(idle_i), .slow_i(slow_i), .bus_req_i(bus_req_i), .unit_en_o(unit_en_o),
    .wake_en_o(wake_en_o), .clk_en_o(clk_en_o), .slow_o(slow_o), .bus_req_o(bus_req_o)
  );

  function automatic logic [5:0] exp_en(logic [5:0] ps, logic idl, logic slw);
    logic [5:0] e = idl ? 6'b0 : ps;
    if (slw) e &= 6'b110001;
    return e;
  endfunction

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    string r_en;
    r_en = idle_i ? "R3" : (m_slow ? "R5" : (prev_idle ? "R4" : "R2"));
    chk(r_en, "unit_en", 8'(unit_en_o), 8'(exp_en(m_psave, idle_i, m_slow)));
    chk("R3", "wake_en", 8'(wake_en_o), 8'(idle_i));
    chk("R6", "bus_req", 8'(bus_req_o), m_slow ? 8'h0 : 8'(bus_req_i));
    chk("R7", "clk_en", 8'(clk_en_o), 8'(!m_slow || m_phase == 0));
    chk("R8", "slow", 8'(slow_o), 8'(m_slow));
  endtask

  task automatic model_reset();
    m_psave = 6'h3F; m_phase = 0; m_slow = 1'b0; prev_idle = 1'b0;
  endtask

  // inputs already applied at negedge; advance one edge and check
  task automatic step();
    logic cur_idle = idle_i;
    @(posedge clk);
    if (psave_we_i) m_psave = psave_wdata_i;
    if (m_phase == DIV - 1) m_slow = slow_i;
    m_phase = (m_phase + 1) % DIV;
    @(negedge clk);
    psave_we_i = 1'b0;
    check_all();
    prev_idle = cur_idle;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    model_reset();
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1", "reset unit_en", 8'(unit_en_o), 8'h3F);
    chk("R1", "reset slow", 8'(slow_o), 8'h0);
    rst_ni = 1'b1;

    // R2: write pattern, then R3 idle, R4 return
    psave_we_i = 1'b1; psave_wdata_i = 6'b101010;
    step();
    chk("R2", "after write", 8'(unit_en_o), 8'h2A);
    idle_i = 1'b1;
    #1 chk("R3", "idle forces off", 8'(unit_en_o), 8'h00);
    step(); step();
    idle_i = 1'b0;
    #1 chk("R4", "idle exit restores", 8'(unit_en_o), 8'h2A);

    // R8: slow request mid-period waits for boundary
    while (m_phase != 1) step();
    slow_i = 1'b1; bus_req_i = 3'b111;
    step();
    chk("R8", "no early slow", 8'(slow_o), 8'h0);
    while (!m_slow) step();
    chk("R5", "slow units off", 8'(unit_en_o), 8'h20);
    chk("R6", "slow req mask", 8'(bus_req_o), 8'h0);
    repeat (DIV * 3) step();
    slow_i = 1'b0;
    while (m_slow) step();
    chk("R5", "slow exit restores", 8'(unit_en_o), 8'h2A);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      psave_we_i    = ($urandom % 8) == 0;
      psave_wdata_i = 6'($urandom);
      idle_i        = ($urandom % 4) == 0;
      if (($urandom % 10) == 0) slow_i = ~slow_i;
      bus_req_i     = 3'($urandom);
      #1 check_all();
      step();
    end

    // R1: asynchronous reset mid-operation
    psave_we_i = 1'b1; psave_wdata_i = 6'b000000; idle_i = 1'b0; slow_i = 1'b1;
    step();
    rst_ni = 1'b0;
    model_reset();
    #1 chk("R1", "async reset unit_en", 8'(unit_en_o), 8'h3F);
    chk("R1", "async reset slow", 8'(slow_o), 8'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    slow_i = 1'b0;
    repeat (8) step();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule